// File: doc/BRIEF.md
# Coarse-Grain Reconfigurable Functional Array

This block is a grid of word-wide arithmetic units that sits beside a simple RISC pipeline and executes custom instructions built from data-flow graphs. Each unit picks two operands through multiplexers. A multiplexer can choose any array input word, any result held from the previous partition, or the output of any unit in a row strictly above its own. Routing only flows downward, so one partition settles as pure combinational logic. Multiplexers in deeper rows have more inputs.

A custom instruction whose graph does not fit in the grid is cut into up to `NPART` partitions. A local configuration memory holds one configuration image per partition. On `start`, a small sequencer runs the partitions in order. For each partition it spends one reconfiguration cycle copying that image into the active configuration registers, then one execute cycle in which the selected unit outputs are captured into the result register. That register feeds the next partition and also drives the result ports. `busy` stalls the host while the sequence runs, and `done` pulses once the final capture has been made.

Top module: `cgra_array`

## Requirements
- R1: After reset, `busy` and `done` are 0, every result word is 0, and every configuration word is 0.
- R2: A unit computes from its 3-bit opcode: 0 a+b, 1 a-b, 2 a arithmetically shifted right by imm, 3 a shifted left by imm, 4 signed a<b giving 1 or 0, 5 a AND b, 6 a XOR b, 7 a plus imm sign-extended from 5 bits.
- R3: Operand source index s picks array input word s for s<NIN, held result word s-NIN for NIN<=s<NIN+NOUT, and unit (row r, column c) for s = NIN+NOUT+r*W+c (defaults: 8 inputs, 4 held words, unit base 12).
- R4: A unit in row r that selects a unit in row r or a lower row, or any index with no source, receives operand 0.
- R5: Output port o drives unit number u = r*W+c when its select is below W*H, and drives 0 when the select is W*H or more.
- R6: With N = `nparts_m1`+1 partitions, `done` is high for exactly one cycle, and that cycle comes 2N clock edges after the edge that samples `start`. `busy` is high from the edge after `start` until `done` rises, and it is low while `done` is high.
- R7: The result register is cleared when a `start` is accepted. Each execute cycle loads it with that partition's output ports, and source selects in later partitions read it as the held words.
- R8: `start` is ignored while `busy` is high.
- R9: A write with `cfg_we` stores `cfg_data` in partition `cfg_part`, slot `cfg_slot`. Slots 0..W*H-1 are unit words laid out {op[19:17], srcA[16:11], srcB[10:5], imm[4:0]}. Slots W*H..W*H+NOUT-1 are output selects in bits [4:0]. A write takes effect at the next load of that partition.
- R10: While idle and without `start`, the result ports do not change, and during a reconfiguration cycle the result register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a custom instruction |
| nparts_m1 | input | PW (2) | Number of partitions minus one |
| in_data | input | NIN*DW (256) | Array input words, word k at bits k*DW |
| cfg_we | input | 1 | Configuration memory write enable |
| cfg_part | input | PW (2) | Partition addressed by the write |
| cfg_slot | input | SLW (5) | Slot addressed by the write |
| cfg_data | input | UCW (20) | Configuration word |
| busy | output | 1 | Sequence running, host must stall |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | NOUT*DW (128) | Result register, word o at bits o*DW |

## Verification
The bound checker watches the control rules on every cycle. These are the single-cycle `done` pulse, `busy` being low at completion, `busy` only rising after an accepted `start`, the result register holding through reconfiguration cycles, and the result ports staying frozen while idle. Operand routing cannot be seen on a cycle-by-cycle basis, so the bench scenarios have to show it: the opcode results, the source index map, the zero returned for upward or same-row selects, the zeroed unused output ports, and values carried between partitions and cleared at `start`. A reference model in the bench predicts these values for both directed and random configurations.

// File: rtl/cgra_pkg.sv
package cgra_pkg;

    localparam int OP_W  = 3;
    localparam int IMM_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SRA  = 3'd2,
        OP_SLL  = 3'd3,
        OP_SLT  = 3'd4,
        OP_AND  = 3'd5,
        OP_XOR  = 3'd6,
        OP_ADDI = 3'd7
    } fu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_EXEC = 2'd2
    } seq_phase_e;

    typedef struct packed {
        logic load;
        logic capture;
        logic clear;
    } seq_ctrl_t;

endpackage

// File: rtl/cgra_fu.sv
module cgra_fu
    import cgra_pkg::*;
#(
    parameter int DW = 32
) (
    input  fu_op_e           op_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [DW-1:0]    y_o
);

    logic [DW-1:0] imm_sx;
    assign imm_sx = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};

    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_SRA:  y_o = $signed(a_i) >>> imm_i;
            OP_SLL:  y_o = a_i << imm_i;
            OP_SLT:  y_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            OP_AND:  y_o = a_i & b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_ADDI: y_o = a_i + imm_sx;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/cgra_opmux.sv
// Operand/result selector; the number of legal sources NV sets its width.
module cgra_opmux #(
    parameter int DW   = 32,
    parameter int SELW = 6,
    parameter int NV   = 12
) (
    input  logic [SELW-1:0]  sel_i,
    input  logic [NV*DW-1:0] pool_i,
    output logic [DW-1:0]    val_o
);

    always_comb begin
        val_o = '0;
        for (int k = 0; k < NV; k++) begin
            if (sel_i == SELW'(k)) val_o = pool_i[k*DW +: DW];
        end
    end

endmodule

// File: rtl/cgra_fabric.sv
module cgra_fabric
    import cgra_pkg::*;
#(
    parameter int W     = 6,
    parameter int H     = 4,
    parameter int DW    = 32,
    parameter int NIN   = 8,
    parameter int NOUT  = 4,
    parameter int SELW  = 6,
    parameter int OSELW = 5,
    localparam int UCW  = OP_W + 2*SELW + IMM_W,
    localparam int NU   = W*H,
    localparam int NFIX = NIN + NOUT
) (
    input  logic [NIN*DW-1:0]    in_i,
    input  logic [NOUT*DW-1:0]   held_i,
    input  logic [NU*UCW-1:0]    ucfg_i,
    input  logic [NOUT*OSELW-1:0] ocfg_i,
    output logic [NOUT*DW-1:0]   out_o
);

    // Each row sees a source pool made of the fixed sources plus all rows above.
    for (genvar r = 0; r < H; r++) begin : g_row
        localparam int NV = NFIX + r*W;
        logic [NV*DW-1:0] pool;
        logic [W*DW-1:0]  y;

        if (r == 0) begin : g_base
            assign pool = {held_i, in_i};
        end else begin : g_chain
            assign pool = {g_row[r-1].y, g_row[r-1].pool};
        end

        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int U = r*W + c;
            logic [UCW-1:0] word;
            logic [DW-1:0]  opa;
            logic [DW-1:0]  opb;

            assign word = ucfg_i[U*UCW +: UCW];

            cgra_opmux #(.DW(DW), .SELW(SELW), .NV(NV)) u_mux_a (
                .sel_i  (word[IMM_W+2*SELW-1 -: SELW]),
                .pool_i (pool),
                .val_o  (opa)
            );

            cgra_opmux #(.DW(DW), .SELW(SELW), .NV(NV)) u_mux_b (
                .sel_i  (word[IMM_W+SELW-1 -: SELW]),
                .pool_i (pool),
                .val_o  (opb)
            );

            cgra_fu #(.DW(DW)) u_fu (
                .op_i  (fu_op_e'(word[UCW-1 -: OP_W])),
                .a_i   (opa),
                .b_i   (opb),
                .imm_i (word[IMM_W-1:0]),
                .y_o   (y[c*DW +: DW])
            );
        end
    end

    logic [(NFIX+NU)*DW-1:0] full_pool;
    logic [NU*DW-1:0]        unit_vals;

    assign full_pool = {g_row[H-1].y, g_row[H-1].pool};
    assign unit_vals = full_pool[NFIX*DW +: NU*DW];

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        cgra_opmux #(.DW(DW), .SELW(OSELW), .NV(NU)) u_omux (
            .sel_i  (ocfg_i[o*OSELW +: OSELW]),
            .pool_i (unit_vals),
            .val_o  (out_o[o*DW +: DW])
        );
    end

endmodule

// File: rtl/cgra_seq.sv
module cgra_seq
    import cgra_pkg::*;
#(
    parameter int NPART = 4,
    localparam int PW   = (NPART > 1) ? $clog2(NPART) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [PW-1:0] nparts_m1,
    output logic [PW-1:0] part_o,
    output seq_ctrl_t     ctrl_o,
    output logic          busy_o,
    output logic          done_o
);

    seq_phase_e    phase;
    logic [PW-1:0] last_part;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            part_o    <= '0;
            last_part <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_LOAD;
                        part_o    <= '0;
                        last_part <= nparts_m1;
                    end
                end
                PH_LOAD: phase <= PH_EXEC;
                PH_EXEC: begin
                    if (part_o == last_part) begin
                        phase  <= PH_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        part_o <= part_o + 1'b1;
                        phase  <= PH_LOAD;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy_o         = (phase != PH_IDLE);
    assign ctrl_o.load    = (phase == PH_LOAD);
    assign ctrl_o.capture = (phase == PH_EXEC);
    assign ctrl_o.clear   = (phase == PH_IDLE) && start;

endmodule

// File: rtl/cgra_array.sv
module cgra_array
    import cgra_pkg::*;
#(
    parameter int W     = 6,
    parameter int H     = 4,
    parameter int DW    = 32,
    parameter int NIN   = 8,
    parameter int NOUT  = 4,
    parameter int NPART = 4,
    localparam int PW    = (NPART > 1) ? $clog2(NPART) : 1,
    localparam int NU    = W*H,
    localparam int SELW  = $clog2(NIN + NOUT + NU),
    localparam int OSELW = $clog2(NU + 1),
    localparam int UCW   = OP_W + 2*SELW + IMM_W,
    localparam int NSLOT = NU + NOUT,
    localparam int SLW   = $clog2(NSLOT),
    localparam int RES_W = NOUT*DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PW-1:0]     nparts_m1,
    input  logic [NIN*DW-1:0] in_data,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_part,
    input  logic [SLW-1:0]    cfg_slot,
    input  logic [UCW-1:0]    cfg_data,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  res_data
);

    logic [UCW-1:0]          cmem [NPART][NSLOT];
    logic [NU*UCW-1:0]       act_ucfg;
    logic [NOUT*OSELW-1:0]   act_ocfg;
    logic [RES_W-1:0]        held;
    logic [RES_W-1:0]        fab_out;
    logic [PW-1:0]           cur_part;
    seq_ctrl_t               ctrl;
    logic                    in_load;

    assign in_load = ctrl.load;

    cgra_seq #(.NPART(NPART)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .nparts_m1 (nparts_m1),
        .part_o    (cur_part),
        .ctrl_o    (ctrl),
        .busy_o    (busy),
        .done_o    (done)
    );

    // Local configuration store, one image per partition.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPART; p++) begin
                for (int s = 0; s < NSLOT; s++) begin
                    cmem[p][s] <= '0;
                end
            end
        end else if (cfg_we && (int'(cfg_part) < NPART) && (int'(cfg_slot) < NSLOT)) begin
            cmem[cfg_part][cfg_slot] <= cfg_data;
        end
    end

    // Reconfiguration cycle: copy the current partition into the active registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_ucfg <= '0;
            act_ocfg <= '0;
        end else if (ctrl.load) begin
            for (int u = 0; u < NU; u++) begin
                act_ucfg[u*UCW +: UCW] <= cmem[cur_part][SLW'(u)];
            end
            for (int o = 0; o < NOUT; o++) begin
                act_ocfg[o*OSELW +: OSELW] <= cmem[cur_part][SLW'(NU + o)][OSELW-1:0];
            end
        end
    end

    cgra_fabric #(
        .W(W), .H(H), .DW(DW), .NIN(NIN), .NOUT(NOUT),
        .SELW(SELW), .OSELW(OSELW)
    ) u_fabric (
        .in_i   (in_data),
        .held_i (held),
        .ucfg_i (act_ucfg),
        .ocfg_i (act_ocfg),
        .out_o  (fab_out)
    );

    // Partition result register.
    always_ff @(posedge clk) begin
        if (rst)               held <= '0;
        else if (ctrl.clear)   held <= '0;
        else if (ctrl.capture) held <= fab_out;
    end

    assign res_data = held;

endmodule

// File: rtl/cgra_array_chk.sv
module cgra_array_chk #(
    parameter int RW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          in_load,
    input logic [RW-1:0] res
);

    // R1: first cycle out of reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: no stall reported while done is high
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: busy only rises after an accepted start
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10: reconfiguration cycle leaves the result register alone
    a_r10_load_holds: assert property (@(posedge clk) disable iff (rst)
        in_load |=> $stable(res));

    // R10: idle results are frozen
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(res));

endmodule

bind cgra_array cgra_array_chk #(.RW(RES_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .in_load (in_load),
    .res     (res_data)
);

// File: tb/tb_cgra_array.sv
module tb_cgra_array;

    localparam int CLK_PERIOD = 10;
    localparam int W = 6, H = 4, DW = 32, NIN = 8, NOUT = 4, NPART = 4;
    localparam int NU = W*H, NSLOT = NU + NOUT;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [1:0]          nparts_m1 = '0;
    logic [NIN*DW-1:0]   in_data = '0;
    logic                cfg_we = 1'b0;
    logic [1:0]          cfg_part = '0;
    logic [4:0]          cfg_slot = '0;
    logic [19:0]         cfg_data = '0;
    logic                busy, done;
    logic [NOUT*DW-1:0]  res_data;

    int checks = 0;
    int errors = 0;

    logic [19:0] bm    [NPART][NSLOT];
    logic [31:0] bin   [NIN];
    logic [31:0] bheld [NOUT];
    logic [31:0] uv    [NU];

    always #(CLK_PERIOD/2) clk = ~clk;

    cgra_array dut (
        .clk(clk), .rst(rst), .start(start), .nparts_m1(nparts_m1),
        .in_data(in_data), .cfg_we(cfg_we), .cfg_part(cfg_part),
        .cfg_slot(cfg_slot), .cfg_data(cfg_data),
        .busy(busy), .done(done), .res_data(res_data)
    );

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ev(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] imm);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return 32'($signed(a) >>> imm);
            3'd3: return a << imm;
            3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd5: return a & b;
            3'd6: return a ^ b;
            default: return a + {{27{imm[4]}}, imm};
        endcase
    endfunction

    function automatic logic [31:0] fetch(int sel, int row);
        if (sel < NIN) return bin[sel];
        if (sel < NIN + NOUT) return bheld[sel - NIN];
        if (sel - NIN - NOUT < row*W) return uv[sel - NIN - NOUT];
        return 32'd0;
    endfunction

    task automatic model_part(int p);
        logic [31:0] nh [NOUT];
        for (int u = 0; u < NU; u++) begin
            logic [19:0] w;
            w = bm[p][u];
            uv[u] = ev(w[19:17], fetch(int'(w[16:11]), u / W), fetch(int'(w[10:5]), u / W), w[4:0]);
        end
        for (int o = 0; o < NOUT; o++) begin
            int s;
            s = int'(bm[p][NU+o][4:0]);
            nh[o] = (s < NU) ? uv[s] : 32'd0;
        end
        for (int o = 0; o < NOUT; o++) bheld[o] = nh[o];
    endtask

    function automatic logic [19:0] uw(int op, int sa, int sb, int imm);
        return {3'(op), 6'(sa), 6'(sb), 5'(imm)};
    endfunction

    task automatic wr(int p, int s, logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_part = 2'(p); cfg_slot = 5'(s); cfg_data = d;
        bm[p][s] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_in();
        for (int k = 0; k < NIN; k++) in_data[k*DW +: DW] = bin[k];
    endtask

    task automatic run_ci(int np, bit restart_mid, string tag);
        int  got;
        logic [NOUT*DW-1:0] snap;
        got = -1;
        for (int o = 0; o < NOUT; o++) bheld[o] = 32'd0;
        for (int p = 0; p < np; p++) model_part(p);
        @(negedge clk);
        drive_in();
        nparts_m1 = 2'(np - 1);
        start = 1'b1;
        @(negedge clk);
        start = restart_mid;
        chk({31'd0, busy}, 32'd1, "R6 busy after start");
        for (int k = 1; k <= 2*NPART + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (done) begin got = k; break; end
            if (!busy) chk({31'd0, busy}, 32'd1, "R6 busy gap");
        end
        chk(32'(got), 32'(2*np), "R6 done cycle");
        chk({31'd0, busy}, 32'd0, "R6 busy low at done");
        for (int o = 0; o < NOUT; o++) chk(res_data[o*DW +: DW], bheld[o], tag);
        snap = res_data;
        @(posedge clk);
        @(negedge clk);
        chk({31'd0, done}, 32'd0, "R6 done single pulse");
        chk({31'd0, (res_data == snap)}, 32'd1, "R10 results hold while idle");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int p = 0; p < NPART; p++)
            for (int s = 0; s < NSLOT; s++) bm[p][s] = '0;
        for (int k = 0; k < NIN; k++) bin[k] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({31'd0, busy}, 32'd0, "R1 busy after reset");
        chk({31'd0, done}, 32'd0, "R1 done after reset");
        for (int o = 0; o < NOUT; o++) chk(res_data[o*DW +: DW], 32'd0, "R1 result after reset");

        // Directed opcode set (R2) with inputs -20 and 7
        bin[0] = 32'hFFFF_FFEC;
        bin[1] = 32'd7;
        for (int k = 2; k < NIN; k++) bin[k] = $urandom;
        wr(0, 0, uw(0, 0, 1, 0));
        wr(0, 1, uw(1, 0, 1, 0));
        wr(0, 2, uw(2, 0, 0, 3));
        wr(0, 3, uw(3, 0, 0, 4));
        wr(0, 4, uw(4, 0, 1, 0));
        wr(0, 5, uw(7, 0, 0, 5'h1E));
        wr(0, 6, uw(5, 0, 1, 0));
        wr(0, 7, uw(6, 0, 1, 0));
        wr(0, 8, uw(0, 12, 20, 0));
        wr(0, 9, uw(0, 0, 19, 0));
        wr(0, 24, 20'd0); wr(0, 25, 20'd1); wr(0, 26, 20'd2); wr(0, 27, 20'd3);
        run_ci(1, 1'b0, "R2 ops model");
        chk(res_data[0*DW +: DW], 32'hFFFF_FFF3, "R2 add");
        chk(res_data[1*DW +: DW], 32'hFFFF_FFE5, "R2 sub");
        chk(res_data[2*DW +: DW], 32'hFFFF_FFFD, "R2 sra");
        chk(res_data[3*DW +: DW], 32'hFFFF_FEC0, "R2 sll");

        // R9: rewriting output selects takes effect on the next run
        wr(0, 24, 20'd4); wr(0, 25, 20'd5); wr(0, 26, 20'd6); wr(0, 27, 20'd7);
        run_ci(1, 1'b0, "R9 reselect model");
        chk(res_data[0*DW +: DW], 32'd1, "R2 slt");
        chk(res_data[1*DW +: DW], 32'hFFFF_FFEA, "R2 addi");
        chk(res_data[2*DW +: DW], 32'd4, "R2 and");
        chk(res_data[3*DW +: DW], 32'hFFFF_FFEB, "R2 xor");

        // R3/R4/R5: downward routing, same-row select gives zero, unused port zero
        wr(0, 5, uw(0, 0, 13, 0));
        wr(0, 24, 20'd8); wr(0, 25, 20'd9); wr(0, 26, 20'd5); wr(0, 27, 20'd31);
        run_ci(1, 1'b0, "R4 routing model");
        chk(res_data[0*DW +: DW], 32'hFFFF_FFF3, "R3 row1 reads row0 unit");
        chk(res_data[1*DW +: DW], 32'hFFFF_FFEC, "R4 row1 same-row select zero");
        chk(res_data[2*DW +: DW], 32'hFFFF_FFEC, "R4 row0 same-row select zero");
        chk(res_data[3*DW +: DW], 32'd0, "R5 unused port zero");

        // R7: second partition reads the held result of the first
        wr(1, 0, uw(0, 8, 1, 0));
        wr(1, 24, 20'd0); wr(1, 25, 20'd31); wr(1, 26, 20'd31); wr(1, 27, 20'd31);
        run_ci(2, 1'b0, "R7 chain model");
        chk(res_data[0*DW +: DW], 32'hFFFF_FFFA, "R7 held chained");

        // R7: held words read as zero in partition 0 (cleared at start)
        wr(0, 11, uw(0, 8, 9, 0));
        wr(0, 27, 20'd11);
        run_ci(1, 1'b0, "R7 clear model");
        chk(res_data[3*DW +: DW], 32'd0, "R7 held cleared at start");

        // R8: extra start while busy changes nothing
        run_ci(2, 1'b1, "R8 restart ignored");
        chk(res_data[0*DW +: DW], 32'hFFFF_FFFA, "R8 result after ignored start");

        // Random configurations against the model (R3, R4, R5, R6, R7, R9)
        for (int t = 0; t < 30; t++) begin
            int np;
            np = 1 + int'($urandom % NPART);
            for (int k = 0; k < NIN; k++) bin[k] = $urandom;
            for (int p = 0; p < np; p++) begin
                for (int u = 0; u < NU; u++)
                    wr(p, u, uw(int'($urandom % 8), int'($urandom % 40),
                                int'($urandom % 40), int'($urandom % 32)));
                for (int o = 0; o < NOUT; o++)
                    wr(p, NU + o, 20'(int'($urandom % 32)));
            end
            run_ci(np, 1'(($urandom % 4) == 0), "R3 random config");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule